// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits on the host side of a 512K x 16 asynchronous pseudo-SRAM and turns single requests from a synchronous valid/ready bus into correctly timed pin sequences. Each request carries a direction, a 19-bit word address, 16 bits of write data and a two-bit byte-lane enable. Reads come back on a separate response port as a one-cycle valid pulse with the data. The controller owns the active-low chip enable, output enable, write enable and the two byte-lane strobes, and it decides when the shared bidirectional data bus is driven.

Every device timing minimum is a parameter in nanoseconds, alongside a clock-period parameter. Each is rounded up to whole clock cycles. The read access window covers both address access and output-enable access. The write-enable pulse covers both the pulse minimum and the data-to-end-of-write overlap. The write cycle is padded with an idle recovery stretch when the pulse alone is shorter than the cycle minimum. After a read, a turnaround counter keeps the controller off the bus until the memory has had time to release it.

With the default 4 ns clock, the cycle counts are 14 for a read, 12 for the write-enable pulse, 14 for the write cycle and 5 for the turnaround.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, mem_ce_n, mem_oe_n and mem_we_n are high, both mem_lane_n bits are high, req_ready is high and rsp_valid is low.
- R2: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly RD_CYC = max(ceil(tAA/tCLK), ceil(tOE/tCLK)) cycles. Counting the acceptance cycle as cycle 0, rsp_valid is high for one cycle in cycle RD_CYC+1 and carries the bus value sampled at the end of the last low cycle.
- R3: req_be bit 0 enables data bits 7:0 and drives mem_lane_n bit 0 low; req_be bit 1 enables bits 15:8 and drives mem_lane_n bit 1 low. A disabled lane reads back as zero and keeps its stored value through a write.
- R4: A request with req_be = 00 keeps both lane strobes high for the whole cycle, changes no stored data and returns zero on a read.
- R5: A write holds mem_we_n low with mem_ce_n low and mem_oe_n high for exactly WL_CYC = max(ceil(tWP/tCLK), ceil(tDW/tCLK)) cycles, and it drives mem_dq with the request's write data for that whole window.
- R6: After a write is accepted, req_ready stays low for at least max(ceil(tWC/tCLK), WL_CYC) cycles. After a read is accepted, it stays low for at least RD_CYC cycles.
- R7: Between mem_oe_n rising at the end of a read and mem_we_n falling for a later write, at least HZ_CYC = ceil(tHZ/tCLK) cycles pass.
- R8: A request is accepted only in a cycle with req_valid and req_ready both high. req_ready is low in the cycle after an acceptance. Every request issued is accepted exactly once.
- R9: mem_addr equals the accepted address and stays stable while mem_ce_n is low, and mem_we_n and mem_oe_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte-lane strobes, active low, bit 0 lower |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The read response pulse and the acceptance of the next request can fall in the same cycle. So can the bus-release turnaround of a read and the arrival of a write that wants to drive the bus. The bench provokes both by queueing the next request while a read is still in progress, so that req_ready returns in the very cycle rsp_valid fires. It then judges the result on two counts. The response must land on its predicted cycle with the right data. The write's enable must fall only after the turnaround count measured from the output-enable release.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WHOLD = 3'd2,
        ST_WR    = 3'd3,
        ST_WREC  = 3'd4
    } psram_st_e;

    // Round a nanosecond interval up to whole clock periods.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_turn.sv
// Bus turnaround guard: counts down after a read releases output enable.
module psram_turn #(
    parameter int CNT_W  = 4,
    parameter int HZ_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = HZ_LD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/psram_rdcap.sv
// Read capture: samples the bus per byte lane and emits the response pulse.
module psram_rdcap #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t r_d, r_q;
    logic [DATA_W-1:0] masked;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*LANE_W +: LANE_W] =
            lane_en[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        r_d     = r_q;
        r_d.vld = cap;
        if (cap) begin
            r_d.data = masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.vld;
    assign rsp_rdata = r_q.data;

endmodule

// File: rtl/psram_seq.sv
// Pin sequencer: request acceptance and the read / write pin phases.
module psram_seq
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int LANES   = 2,
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 14,
    parameter int WL_CYC  = 12,
    parameter int REC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              turn_busy,
    output logic              rd_done,
    output logic [LANES-1:0]  be_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic              dq_drv,
    output logic [DATA_W-1:0] dq_out
);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WL_LD  = CNT_W'(WL_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);
    localparam bit               HAS_REC = (REC_CYC > 0);

    typedef struct packed {
        psram_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  lane_n;
        logic              drv;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        addr:   '0,
        wdata:  '0,
        be:     '0,
        ce_n:   1'b1,
        oe_n:   1'b1,
        we_n:   1'b1,
        lane_n: '1,
        drv:    1'b0
    };

    seq_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        rd_done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be    = req_be;
                    if (!req_write) begin
                        r_d.st     = ST_RD;
                        r_d.cnt    = RD_LD;
                        r_d.ce_n   = 1'b0;
                        r_d.oe_n   = 1'b0;
                        r_d.lane_n = ~req_be;
                    end else if (turn_busy) begin
                        r_d.st = ST_WHOLD;
                    end else begin
                        r_d.st     = ST_WR;
                        r_d.cnt    = WL_LD;
                        r_d.ce_n   = 1'b0;
                        r_d.we_n   = 1'b0;
                        r_d.lane_n = ~req_be;
                        r_d.drv    = 1'b1;
                    end
                end
            end
            ST_RD: begin
                if (r_q.cnt == '0) begin
                    rd_done    = 1'b1;
                    r_d.st     = ST_IDLE;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.lane_n = '1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (!turn_busy) begin
                    r_d.st     = ST_WR;
                    r_d.cnt    = WL_LD;
                    r_d.ce_n   = 1'b0;
                    r_d.we_n   = 1'b0;
                    r_d.lane_n = ~r_q.be;
                    r_d.drv    = 1'b1;
                end
            end
            ST_WR: begin
                if (r_q.cnt == '0) begin
                    r_d.we_n   = 1'b1;
                    r_d.ce_n   = 1'b1;
                    r_d.lane_n = '1;
                    r_d.drv    = 1'b0;
                    if (HAS_REC) begin
                        r_d.st  = ST_WREC;
                        r_d.cnt = REC_LD;
                    end else begin
                        r_d.st  = ST_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WREC: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign be_q       = r_q.be;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_lane_n = r_q.lane_n;
    assign dq_drv     = r_q.drv;
    assign dq_out     = r_q.wdata;

endmodule

// File: rtl/psram_ctrl.sv
// Top: asynchronous pseudo-SRAM access controller.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int LANE_W  = 8,
    parameter int CLK_NS  = 4,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 25,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 45,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [DATA_W/LANE_W-1:0]   req_be,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_ce_n,
    output logic                       mem_oe_n,
    output logic                       mem_we_n,
    output logic [DATA_W/LANE_W-1:0]   mem_lane_n,
    inout  wire  [DATA_W-1:0]          mem_dq
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int RD_CYC  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int WL_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC = (WC_CYC > WL_CYC) ? WC_CYC - WL_CYC : 0;
    localparam int HZ_CYC  = imax(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
    localparam int MAX_CYC = imax(imax(RD_CYC, WL_CYC), imax(REC_CYC, HZ_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              rd_done;
    logic              turn_busy;
    logic              dq_drv;
    logic [DATA_W-1:0] dq_out;
    logic [LANES-1:0]  be_q;

    psram_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LANES   (LANES),
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .WL_CYC  (WL_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .turn_busy  (turn_busy),
        .rd_done    (rd_done),
        .be_q       (be_q),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lane_n (mem_lane_n),
        .dq_drv     (dq_drv),
        .dq_out     (dq_out)
    );

    psram_turn #(
        .CNT_W  (CNT_W),
        .HZ_CYC (HZ_CYC)
    ) u_turn (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_done),
        .busy  (turn_busy)
    );

    psram_rdcap #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (rd_done),
        .lane_en   (be_q),
        .dq_in     (mem_dq),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_dq = dq_drv ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/psram_ctrl_chk.sv
// Pin-timing checker, bound into the controller top.
module psram_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int RD_CYC = 14,
    parameter int WL_CYC = 12,
    parameter int HZ_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dq_drv
);
    logic [15:0] oe_len, we_len, since_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_len   <= '0;
            we_len   <= '0;
            since_oe <= '1;
        end else begin
            oe_len   <= mem_oe_n ? 16'd0 : oe_len + 16'd1;
            we_len   <= mem_we_n ? 16'd0 : we_len + 16'd1;
            if (!mem_oe_n) begin
                since_oe <= '0;
            end else if (since_oe != '1) begin
                since_oe <= since_oe + 16'd1;
            end
        end
    end

    // R2: output-enable window length
    p_oe_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_len == 16'(RD_CYC)));

    // R2: response follows a cycle with output enable low, and is a pulse
    p_rsp_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: write-enable pulse length
    p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_len == 16'(WL_CYC)));

    // R5: bus is driven only with chip enable low and output enable high
    p_drive_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drv |-> (!mem_ce_n && mem_oe_n));

    // R7: turnaround after a read before any write pulse
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (since_oe >= 16'(HZ_CYC)));

    // R8: ready drops after an acceptance
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: address stable while selected; enables never overlap
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .RD_CYC (RD_CYC),
    .WL_CYC (WL_CYC),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .dq_drv    (dq_drv)
);

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;

    // Expected cycle counts from the requirements, 4 ns clock.
    localparam int CK     = 4;
    localparam int B_AA   = (55 + CK - 1) / CK;
    localparam int B_OE   = (25 + CK - 1) / CK;
    localparam int B_RD   = (B_AA > B_OE) ? B_AA : B_OE;
    localparam int B_WP   = (45 + CK - 1) / CK;
    localparam int B_DW   = (30 + CK - 1) / CK;
    localparam int B_WL   = (B_WP > B_DW) ? B_WP : B_DW;
    localparam int B_WC0  = (55 + CK - 1) / CK;
    localparam int B_WC   = (B_WC0 > B_WL) ? B_WC0 : B_WL;
    localparam int B_HZ   = (20 + CK - 1) / CK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    wire  [15:0] mem_dq;

    always #2 clk = ~clk;

    psram_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lane_n (mem_lane_n),
        .mem_dq     (mem_dq)
    );

    // Pin-level memory model
    logic [15:0] pin_mem [int];
    logic [15:0] mdl_word = '0;
    wire rd_en = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_en && !mem_lane_n[0]) ? mdl_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_en && !mem_lane_n[1]) ? mdl_word[15:8] : 8'hzz;

    // Behavioural reference state
    logic [15:0] ref_mem [int];
    longint      due_q [$];
    logic [15:0] dat_q [$];
    longint      cyc = 0;
    int          total = 0, bad = 0;
    int          issued = 0, accepts = 0;
    logic [18:0] cur_addr = '0;
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_be = '0;
    bit          last_wr = 1'b0, just_acc = 1'b0, finished = 1'b0;
    logic        p_oe_n = 1'b1, p_we_n = 1'b1, p_ready = 1'b1;
    int          oe_len = 0, we_len = 0, since_oe = 1000, rdy_low = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_ref(input logic [15:0] m [int], input int a);
        return m.exists(a) ? m[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor and reference comparison, every clock at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            // write commit into the pin model
            if (!mem_ce_n && !mem_we_n) begin
                logic [15:0] w;
                w = rd_ref(pin_mem, int'(mem_addr));
                if (!mem_lane_n[0]) w[7:0]  = mem_dq[7:0];
                if (!mem_lane_n[1]) w[15:8] = mem_dq[15:8];
                pin_mem[int'(mem_addr)] = w;
            end
            // write-enable window (R5) and turnaround (R7)
            if (!mem_we_n) begin
                if (p_we_n) chk(since_oe >= B_HZ, "R7", "oe-high cycles before we fall", since_oe, B_HZ);
                we_len++;
                chk(mem_dq == cur_wdata, "R5", "bus data during write", mem_dq, cur_wdata);
                chk(mem_oe_n && !mem_ce_n, "R5", "oe_n/ce_n during write", {mem_oe_n, mem_ce_n}, 2'b10);
            end else if (!p_we_n) begin
                chk(we_len == B_WL, "R5", "we_n low length", we_len, B_WL);
                we_len = 0;
            end
            // output-enable window (R2)
            if (!mem_oe_n) begin
                oe_len++;
                since_oe = 0;
                chk(!mem_ce_n && mem_we_n, "R2", "ce_n/we_n during read", {mem_ce_n, mem_we_n}, 2'b01);
            end else begin
                if (!p_oe_n) begin
                    chk(oe_len == B_RD, "R2", "oe_n low length", oe_len, B_RD);
                    oe_len = 0;
                end
                since_oe++;
            end
            // strobes and address while selected (R3, R4, R9)
            if (!mem_ce_n) begin
                if (cur_be == 2'b00)
                    chk(mem_lane_n == 2'b11, "R4", "lane strobes with no lanes", mem_lane_n, 2'b11);
                else
                    chk(mem_lane_n == ~cur_be, "R3", "lane strobes", mem_lane_n, ~cur_be);
                chk(mem_addr == cur_addr, "R9", "address while selected", mem_addr, cur_addr);
            end
            chk(mem_we_n || mem_oe_n, "R9", "we_n and oe_n both low", {mem_we_n, mem_oe_n}, 2'b11);
            // response against reference (R2, R3, R4)
            if (rsp_valid) begin
                if (due_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected rsp_valid", 1, 0);
                end else begin
                    longint      d;
                    logic [15:0] e;
                    d = due_q.pop_front();
                    e = dat_q.pop_front();
                    chk(d == cyc, "R2", "response cycle", cyc, d);
                    chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                chk(1'b0, "R2", "missing rsp_valid", 0, 1);
                void'(due_q.pop_front());
                void'(dat_q.pop_front());
            end
            // ready behaviour (R6, R8)
            if (just_acc) chk(!req_ready, "R8", "ready after acceptance", req_ready, 0);
            just_acc = 1'b0;
            if (!req_ready) begin
                rdy_low++;
            end else if (!p_ready) begin
                if (last_wr) chk(rdy_low >= B_WC, "R6", "write ready-low cycles", rdy_low, B_WC);
                else         chk(rdy_low >= B_RD, "R6", "read ready-low cycles", rdy_low, B_RD);
                rdy_low = 0;
            end
            // acceptance
            if (req_valid && req_ready) begin
                accepts++;
                just_acc  = 1'b1;
                cur_addr  = req_addr;
                cur_wdata = req_wdata;
                cur_be    = req_be;
                last_wr   = req_write;
                if (req_write) begin
                    logic [15:0] o, m;
                    o = rd_ref(ref_mem, int'(req_addr));
                    m = lane_mask(req_be);
                    ref_mem[int'(req_addr)] = (o & ~m) | (req_wdata & m);
                end else begin
                    due_q.push_back(cyc + B_RD + 1);
                    dat_q.push_back(rd_ref(ref_mem, int'(req_addr)) & lane_mask(req_be));
                end
            end
            mdl_word = rd_ref(pin_mem, int'(mem_addr));
            p_oe_n  = mem_oe_n;
            p_we_n  = mem_we_n;
            p_ready = req_ready;
        end
        if (cyc > 60000 && !finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog R8 actual=%0d expected=<60000", cyc);
            finish_up();
        end
    end

    task automatic op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                      input logic [1:0] be);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        issued++;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "enables in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(mem_lane_n == 2'b11, "R1", "strobes in reset", mem_lane_n, 2'b11);
        chk(req_ready && !rsp_valid, "R1", "ready/rsp in reset", {req_ready, rsp_valid}, 2'b10);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "enables after reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(req_ready && !rsp_valid, "R1", "ready/rsp after reset", {req_ready, rsp_valid}, 2'b10);

        // R2 R5: full word write then read
        op(1'b1, 19'h00123, 16'h1234, 2'b11);
        op(1'b0, 19'h00123, 16'h0000, 2'b11);
        // R3: lower-lane write keeps the upper byte; partial reads
        op(1'b1, 19'h00123, 16'hABCD, 2'b01);
        op(1'b0, 19'h00123, 16'h0000, 2'b11);
        op(1'b0, 19'h00123, 16'h0000, 2'b10);
        op(1'b0, 19'h00123, 16'h0000, 2'b01);
        op(1'b1, 19'h00123, 16'h5A00, 2'b10);
        op(1'b0, 19'h00123, 16'h0000, 2'b11);
        // R4: no-lane write changes nothing; no-lane read returns zero
        op(1'b1, 19'h00123, 16'hFFFF, 2'b00);
        op(1'b0, 19'h00123, 16'h0000, 2'b11);
        op(1'b0, 19'h00123, 16'h0000, 2'b00);
        // address extremes
        op(1'b1, 19'h00000, 16'h0F0F, 2'b11);
        op(1'b1, 19'h7FFFF, 16'hF0F0, 2'b11);
        op(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        op(1'b0, 19'h00000, 16'h0000, 2'b11);
        // R7: write directly after a read; response and acceptance share a cycle
        op(1'b0, 19'h00000, 16'h0000, 2'b11);
        op(1'b1, 19'h00000, 16'h3C3C, 2'b11);
        op(1'b0, 19'h00000, 16'h0000, 2'b11);
        // mixed sequence over a small address set
        for (int i = 0; i < 48; i++) begin
            logic [18:0] a;
            a = 19'(((i * 5) % 8) * 65521);
            op((i % 3) != 2, a, 16'(i * 40503 + 1), 2'(i % 4));
        end
        repeat (2 * B_RD + 4) @(negedge clk);
        chk(due_q.size() == 0, "R2", "responses outstanding", due_q.size(), 0);
        chk(accepts == issued, "R8", "accepted vs issued", accepts, issued);
        finished = 1'b1;
        finish_up();
    end

endmodule